// File: doc/BRIEF.md
# Interrupt Status Aggregator with Mask and Mute

This block gathers the event pulses raised by a display data channel controller (command finished, read request, target not acknowledging, bus arbitration lost) into a small write-1-to-clear status register. It drives a single level-sensitive interrupt line. Software reaches it through a simple register port: a write strobe with address and data, and a combinational read-data output for whatever address is presented.

Two independent filter layers sit between the events and the interrupt line. A mask bit stops its source completely: the event neither records a status bit nor raises the line. A mute bit acts after the status register: the event is still recorded and can be polled, but that status bit is kept off the interrupt line. The two error sources share one error status bit. Each error source has its own mask bit.

Top module: `intr_agg`

## Requirements
- R1: After reset the status and mute registers read 0x00 and irq_o is low. Both mask registers read 0x44, with all sources masked.
- R2: An unmasked event sets its status bit on the next clock edge. Read request sets bit 2, command done sets bit 1, and error sets bit 0 of the status register at address 0.
- R3: A NACK event and an arbitration-lost event each set status bit 0, unless that source's own mask bit is set.
- R4: A masked event leaves its status bit unchanged. The done-mask register at address 2 masks read request with bit 6 and command done with bit 2. The error-mask register at address 3 masks NACK with bit 6 and arbitration lost with bit 2.
- R5: A write to address 0 clears every status bit whose data bit is 1 and leaves bits written with 0 unchanged.
- R6: When an unmasked event and a clearing write hit the same status bit in one cycle, the bit ends up set.
- R7: irq_o is high exactly when some status bit is set while its mute bit is clear. The mute register at address 1 uses bits 2..0, in the same positions as the status bits. A muted event still sets its status bit.
- R8: Register bits with no function read as 0, and writes to them have no effect. Any address other than 0 to 3 reads 0x00, and a write to such an address changes no state.
- R9: Changing a mask bit does not clear a status bit that is already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_rd_req_i | input | 1 | Read-request event pulse |
| evt_cmd_done_i | input | 1 | Command-done event pulse |
| evt_nack_i | input | 1 | Target-not-acknowledged error pulse |
| evt_arb_lost_i | input | 1 | Arbitration-lost error pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Read data for reg_addr_i (combinational) |
| irq_o | output | 1 | Level interrupt output |

## Verification
The bench builds the block with ADDR_W set to 3 instead of the default 2. This puts addresses 4 to 7 within reach, so reads and writes to unmapped locations can be shown to return zero and to change no state. DATA_W stays at 8, so every unused bit in the mute and mask registers can be written and read back. The random phase mixes clearing writes with simultaneous events, and mask or mute changes with pending status.

// File: rtl/intr_agg_pkg.sv
package intr_agg_pkg;
  localparam int NUM_SRC  = 3;
  // status / mute bit positions
  localparam int ST_ERR   = 0;
  localparam int ST_DONE  = 1;
  localparam int ST_RDREQ = 2;
  // mask bit positions within both mask registers
  localparam int MSK_LO   = 2;
  localparam int MSK_HI   = 6;
  // register map
  localparam int ADDR_STATUS = 0;
  localparam int ADDR_MUTE   = 1;
  localparam int ADDR_DMASK  = 2;
  localparam int ADDR_EMASK  = 3;

  typedef logic [NUM_SRC-1:0] src_vec_t;
  typedef struct packed {
    logic hi;
    logic lo;
  } mask_pair_t;
endpackage

// File: rtl/intr_ctrl_regs.sv
module intr_ctrl_regs
  import intr_agg_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output src_vec_t          mute_o,
  output mask_pair_t        dmask_o,
  output mask_pair_t        emask_o
);
  logic we_mute, we_dmask, we_emask;
  assign we_mute  = we_i && (addr_i == ADDR_W'(ADDR_MUTE));
  assign we_dmask = we_i && (addr_i == ADDR_W'(ADDR_DMASK));
  assign we_emask = we_i && (addr_i == ADDR_W'(ADDR_EMASK));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mute_o  <= '0;
      dmask_o <= '1;
      emask_o <= '1;
    end else begin
      if (we_mute)  mute_o  <= wdata_i[NUM_SRC-1:0];
      if (we_dmask) dmask_o <= '{hi: wdata_i[MSK_HI], lo: wdata_i[MSK_LO]};
      if (we_emask) emask_o <= '{hi: wdata_i[MSK_HI], lo: wdata_i[MSK_LO]};
    end
  end

  logic unused_bits;
  assign unused_bits = ^wdata_i;
endmodule

// File: rtl/intr_event_gate.sv
module intr_event_gate
  import intr_agg_pkg::*;
(
  input  logic       rd_req_i,
  input  logic       cmd_done_i,
  input  logic       nack_i,
  input  logic       arb_lost_i,
  input  mask_pair_t dmask_i,
  input  mask_pair_t emask_i,
  output src_vec_t   set_o
);
  always_comb begin
    set_o           = '0;
    set_o[ST_RDREQ] = rd_req_i   & ~dmask_i.hi;
    set_o[ST_DONE]  = cmd_done_i & ~dmask_i.lo;
    set_o[ST_ERR]   = (nack_i & ~emask_i.hi) | (arb_lost_i & ~emask_i.lo);
  end
endmodule

// File: rtl/intr_status_w1c.sv
module intr_status_w1c
  import intr_agg_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  src_vec_t set_i,
  input  src_vec_t clr_i,
  output src_vec_t status_o
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       status_o[i] <= 1'b0;
      else if (set_i[i]) status_o[i] <= 1'b1;  // event beats clear
      else if (clr_i[i]) status_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/intr_agg.sv
module intr_agg
  import intr_agg_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_rd_req_i,
  input  logic              evt_cmd_done_i,
  input  logic              evt_nack_i,
  input  logic              evt_arb_lost_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  src_vec_t   status_q, mute_q, set_vec, clr_vec;
  mask_pair_t dmask_q, emask_q;

  intr_ctrl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .mute_o  (mute_q),
    .dmask_o (dmask_q),
    .emask_o (emask_q)
  );

  intr_event_gate u_gate (
    .rd_req_i   (evt_rd_req_i),
    .cmd_done_i (evt_cmd_done_i),
    .nack_i     (evt_nack_i),
    .arb_lost_i (evt_arb_lost_i),
    .dmask_i    (dmask_q),
    .emask_i    (emask_q),
    .set_o      (set_vec)
  );

  assign clr_vec = (reg_we_i && reg_addr_i == ADDR_W'(ADDR_STATUS))
                   ? reg_wdata_i[NUM_SRC-1:0] : '0;

  intr_status_w1c u_stat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_vec),
    .clr_i    (clr_vec),
    .status_o (status_q)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADDR_W'(ADDR_STATUS): reg_rdata_o[NUM_SRC-1:0] = status_q;
      ADDR_W'(ADDR_MUTE):   reg_rdata_o[NUM_SRC-1:0] = mute_q;
      ADDR_W'(ADDR_DMASK): begin
        reg_rdata_o[MSK_HI] = dmask_q.hi;
        reg_rdata_o[MSK_LO] = dmask_q.lo;
      end
      ADDR_W'(ADDR_EMASK): begin
        reg_rdata_o[MSK_HI] = emask_q.hi;
        reg_rdata_o[MSK_LO] = emask_q.lo;
      end
      default: reg_rdata_o = '0;
    endcase
  end

  assign irq_o = |(status_q & ~mute_q);
endmodule

// File: rtl/intr_agg_chk.sv
module intr_agg_chk
  import intr_agg_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       evt_rd_req_i,
  input logic       evt_cmd_done_i,
  input logic       evt_nack_i,
  input logic       irq_o,
  input src_vec_t   status_q,
  input src_vec_t   mute_q,
  input mask_pair_t dmask_q,
  input mask_pair_t emask_q
);
  // R2
  done_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_cmd_done_i && !dmask_q.lo) |=> status_q[ST_DONE]);
  // R2
  rdreq_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_rd_req_i && !dmask_q.hi) |=> status_q[ST_RDREQ]);
  // R3
  nack_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_nack_i && !emask_q.hi) |=> status_q[ST_ERR]);
  // R4
  masked_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_q[ST_DONE]) |-> $past(evt_cmd_done_i && !dmask_q.lo));
  // R4
  masked_rdreq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_q[ST_RDREQ]) |-> $past(evt_rd_req_i && !dmask_q.hi));
  // R7
  irq_needs_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (status_q != '0));
endmodule

bind intr_agg intr_agg_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .evt_rd_req_i   (evt_rd_req_i),
  .evt_cmd_done_i (evt_cmd_done_i),
  .evt_nack_i     (evt_nack_i),
  .irq_o          (irq_o),
  .status_q       (status_q),
  .mute_q         (mute_q),
  .dmask_q        (dmask_q),
  .emask_q        (emask_q)
);

// File: tb/intr_agg_test.sv
module intr_agg_test;
  localparam int AW = 3;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_rd = 0, ev_done = 0, ev_nack = 0, ev_arb = 0;
  logic we = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic irq;

  int vectors = 0, errors = 0;
  // reference state
  int m_st = 0, m_mute = 0, m_dmask = 8'h44, m_emask = 8'h44;

  always #10 clk = ~clk;

  intr_agg #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .evt_rd_req_i(ev_rd), .evt_cmd_done_i(ev_done),
    .evt_nack_i(ev_nack), .evt_arb_lost_i(ev_arb),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  function automatic int ref_read(int a);
    case (a)
      0: return m_st;
      1: return m_mute;
      2: return m_dmask;
      3: return m_emask;
      default: return 0;
    endcase
  endfunction

  task automatic compare(string tag);
    int exp_rd = ref_read(int'(addr));
    logic exp_irq = (m_st & ~m_mute & 7) != 0;
    vectors++;
    if (rdata !== DW'(exp_rd)) begin
      errors++;
      $display("FAIL %s rdata addr=%0d got=%02h exp=%02h", tag, addr, rdata, exp_rd);
    end
    vectors++;
    if (irq !== exp_irq) begin
      errors++;
      $display("FAIL R7 (%s) irq got=%0b exp=%0b", tag, irq, exp_irq);
    end
  endtask

  // drive at negedge, compare mid-low, advance model at posedge
  task automatic step(string tag, bit r, bit d, bit n, bit a,
                      bit w, int ad, int wd);
    int set;
    @(negedge clk);
    ev_rd = r; ev_done = d; ev_nack = n; ev_arb = a;
    we = w; addr = AW'(ad); wdata = DW'(wd);
    #5 compare(tag);
    @(posedge clk);
    set = 0;
    if (r && !m_dmask[6]) set |= 4;
    if (d && !m_dmask[2]) set |= 2;
    if ((n && !m_emask[6]) || (a && !m_emask[2])) set |= 1;
    if (w) begin
      case (ad)
        0: m_st = m_st & ~(wd & 7);
        1: m_mute = wd & 7;
        2: m_dmask = wd & 8'h44;
        3: m_emask = wd & 8'h44;
        default: ;
      endcase
    end
    m_st = m_st | set;
  endtask

  task automatic rd(string tag, int ad);
    step(tag, 0, 0, 0, 0, 0, ad, 0);
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #45 rst_n = 1'b1;
    // R1 reset values
    for (int a = 0; a < 4; a++) rd("R1", a);
    // R4 masked events record nothing
    step("R4", 1, 1, 1, 1, 0, 0, 0);
    rd("R4", 0);
    // unmask everything
    step("R2", 0, 0, 0, 0, 1, 2, 0);
    step("R3", 0, 0, 0, 0, 1, 3, 0);
    step("R2", 1, 0, 0, 0, 0, 0, 0);
    rd("R2", 0);
    step("R2", 0, 1, 0, 0, 0, 0, 0);
    rd("R2", 0);
    // R5 partial clear: clear bit 2 only
    step("R5", 0, 0, 0, 0, 1, 0, 4);
    rd("R5", 0);
    step("R5", 0, 0, 0, 0, 1, 0, 8'hF8);
    rd("R5", 0);
    step("R5", 0, 0, 0, 0, 1, 0, 2);
    rd("R5", 0);
    // R3 each error source alone
    step("R3", 0, 0, 1, 0, 0, 0, 0);
    rd("R3", 0);
    step("R3", 0, 0, 0, 0, 1, 0, 1);
    step("R3", 0, 0, 0, 1, 0, 0, 0);
    rd("R3", 0);
    // R3 mask nack only, arbitration still sets
    step("R3", 0, 0, 0, 0, 1, 3, 8'h40);
    step("R3", 0, 0, 0, 0, 1, 0, 1);
    step("R3", 0, 0, 1, 0, 0, 0, 0);
    rd("R3", 0);
    step("R3", 0, 0, 0, 1, 0, 0, 0);
    rd("R3", 0);
    // R6 event beats clear in same cycle
    step("R6", 0, 1, 0, 0, 1, 0, 7);
    rd("R6", 0);
    // R7 mute keeps status but drops irq
    step("R7", 0, 0, 0, 0, 1, 1, 7);
    step("R7", 1, 0, 0, 0, 0, 1, 0);
    rd("R7", 0);
    step("R7", 0, 0, 0, 0, 1, 1, 3);
    rd("R7", 1);
    // R9 re-mask with pending status
    step("R9", 0, 0, 0, 0, 1, 2, 8'hFF);
    rd("R9", 0);
    // R8 unused bits and unmapped addresses
    step("R8", 0, 0, 0, 0, 1, 1, 8'hF8);
    rd("R8", 1);
    step("R8", 0, 0, 0, 0, 1, 5, 8'hFF);
    for (int a = 4; a < 8; a++) rd("R8", a);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      bit w = ($urandom_range(0, 2) == 0);
      step("R8", $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0,
           $urandom_range(0, 5) == 0, $urandom_range(0, 5) == 0,
           w, $urandom_range(0, 7), $urandom_range(0, 255));
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule